// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block stands between the asynchronous bus control pins of a parallel NOR-flash-style memory and its command state machine. It samples chip enable, write enable and output enable (all active low) with a fast internal clock. It also samples a digital flag that reports a supply voltage below the lockout level. From these inputs it decides which host bus cycles count as real writes.

Each pin is brought into the clock domain and then passed through a pulse-width filter, so short noise pulses never reach the decision logic. A write is armed only when the filtered pins show chip enable low, write enable low and output enable high. The write is accepted with a single-cycle strobe when write enable or chip enable returns high. Two further guards sit on top of this. A power-up guard refuses a write whose pins were already in the write combination when reset ended. A low-supply lockout holds the command logic in reset and discards every write, including one that is already in progress.

Top module: `wq_write_guard`

## Requirements
- R1: While `rst` is high and afterwards until the synchronized lockout flag reads low, `wr_strobe` is 0 and `cmd_reset` is 1; the filtered pin levels start in the asserted (low) state.
- R2: A new level on any control pin takes effect only after it has been present for `GLITCH_CYC` consecutive synchronized samples; a shorter pulse on any pin has no effect on `wr_strobe`.
- R3: A write is armed only when the filtered levels show `ce_n`=0, `we_n`=0 and `oe_n`=1; `oe_n` low, `ce_n` high or `we_n` high each, on its own, prevents arming.
- R4: If filtered `oe_n` goes low while a write is armed, the write is dropped and produces no strobe.
- R5: `wr_strobe` is high for exactly one cycle per accepted write. It rises `SYNC_STAGES`+`GLITCH_CYC`+1 clock edges after the pin edge that ends the write.
- R6: If `ce_n` and `we_n` are both low when reset ends, no write is accepted until filtered `we_n` or `ce_n` has been seen high.
- R7: While the synchronized `vcc_low` is 1, `cmd_reset` is 1 (one cycle after the synchronized flag), no strobe is issued, and an armed write is discarded.
- R8: After `vcc_low` clears, the block behaves as after power-up: a write whose pins are still low is not accepted, and qualification resumes once `we_n` or `ce_n` has been seen high.
- R9: A write ended by `ce_n` rising while `we_n` stays low is accepted exactly like one ended by `we_n` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high (power-up) |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| vcc_low | input | 1 | Supply below lockout level, active high, asynchronous |
| wr_strobe | output | 1 | One-cycle pulse for each accepted write |
| cmd_reset | output | 1 | Holds the command register and its state machine in reset (read-array) |

## Verification
The assertions check several rules on every cycle. A strobe never lasts more than one cycle. A strobe never coincides with the command reset. The command reset follows the synchronized lockout. A filtered level only ever moves to the value the synchronizer presents. A strobe only follows a cycle with output enable high and a write-ending pin high. Other behaviours depend on a history of several cycles, and only the bench scenarios can show them. These are rejecting a pulse one cycle short of the threshold while accepting one exactly at it, the power-up refusal, aborts through output enable or lockout, and the end of a write by chip enable. The bench checks each of these against a cycle-level reference model and against per-scenario strobe counts.

// File: rtl/wq_pkg.sv
package wq_pkg;

    typedef enum logic [1:0] {
        QS_WAIT   = 2'd0,
        QS_IDLE   = 2'd1,
        QS_ACTIVE = 2'd2
    } qstate_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_pins_t;

    localparam int NUM_PINS = $bits(ctl_pins_t);

    function automatic logic write_start(ctl_pins_t p);
        return !p.ce_n && !p.we_n && p.oe_n;
    endfunction

    function automatic logic cycle_end(ctl_pins_t p);
        return p.ce_n || p.we_n;
    endfunction

endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/wq_filter.sv
module wq_filter #(
    parameter int   GLITCH_CYC = 4,
    parameter logic RST_VAL    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= RST_VAL;
            cnt <= '0;
        end else if (d == q) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            q   <= d;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wq_qualify.sv
module wq_qualify
    import wq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_pins_t lvl,
    input  logic      lock,
    output logic      strobe,
    output logic      cmd_reset
);
    qstate_e st, st_nx;
    logic    strobe_nx;

    always_comb begin
        st_nx     = st;
        strobe_nx = 1'b0;
        if (lock) begin
            st_nx = QS_WAIT;
        end else begin
            case (st)
                QS_WAIT:   if (cycle_end(lvl)) st_nx = QS_IDLE;
                QS_IDLE:   if (write_start(lvl)) st_nx = QS_ACTIVE;
                QS_ACTIVE: begin
                    if (!lvl.oe_n) begin
                        st_nx = cycle_end(lvl) ? QS_IDLE : QS_WAIT;
                    end else if (cycle_end(lvl)) begin
                        strobe_nx = 1'b1;
                        st_nx     = QS_IDLE;
                    end
                end
                default:   st_nx = QS_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= QS_WAIT;
            strobe    <= 1'b0;
            cmd_reset <= 1'b1;
        end else begin
            st        <= st_nx;
            strobe    <= strobe_nx;
            cmd_reset <= lock;
        end
    end
endmodule

// File: rtl/wq_write_guard.sv
module wq_write_guard
    import wq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic vcc_low,
    output logic wr_strobe,
    output logic cmd_reset
);
    logic [NUM_PINS-1:0] raw_lvl;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] filt_lvl;
    logic                lock_s;
    ctl_pins_t           lvl;

    assign raw_lvl = {ce_n, we_n, oe_n};

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        wq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk(clk), .rst(rst), .d(raw_lvl[i]), .q(sync_lvl[i])
        );
        wq_filter #(.GLITCH_CYC(GLITCH_CYC), .RST_VAL(1'b0)) u_filt (
            .clk(clk), .rst(rst), .d(sync_lvl[i]), .q(filt_lvl[i])
        );
    end

    wq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lock_sync (
        .clk(clk), .rst(rst), .d(vcc_low), .q(lock_s)
    );

    assign lvl = ctl_pins_t'(filt_lvl);

    wq_qualify u_qual (
        .clk(clk), .rst(rst), .lvl(lvl), .lock(lock_s),
        .strobe(wr_strobe), .cmd_reset(cmd_reset)
    );
endmodule

// File: rtl/wq_write_guard_chk.sv
module wq_write_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_strobe,
    input logic       cmd_reset,
    input logic       lock_s,
    input logic [2:0] sync_lvl,
    input logic [2:0] filt_lvl
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    a_r7_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |-> !wr_strobe);

    a_r7_lock_resets: assert property (@(posedge clk) disable iff (rst)
        lock_s |=> cmd_reset);

    a_r3_strobe_oe_high: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(filt_lvl[0]));

    a_r9_strobe_after_end: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(filt_lvl[2] || filt_lvl[1]));

    for (genvar i = 0; i < 3; i++) begin : g_flt
        a_r2_filter_follows: assert property (@(posedge clk) disable iff (rst)
            !$stable(filt_lvl[i]) |-> ($past(sync_lvl[i]) == filt_lvl[i]));
    end
endmodule

bind wq_write_guard wq_write_guard_chk i_chk (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .cmd_reset(cmd_reset),
    .lock_s(lock_s), .sync_lvl(sync_lvl), .filt_lvl(filt_lvl)
);

// File: tb/test_wq_write_guard.sv
`timescale 1ns/1ps
module test_wq_write_guard;
    localparam int SYNC = 2;
    localparam int G    = 4;

    logic clk = 0;
    logic rst = 1;
    logic ce_n = 0, we_n = 0, oe_n = 1, vcc_low = 0;
    logic wr_strobe, cmd_reset;

    int total = 0, bad = 0, nstrobe = 0;
    bit cmp_en = 0, done = 0;

    always #10 clk = ~clk;

    wq_write_guard #(.SYNC_STAGES(SYNC), .GLITCH_CYC(G)) i_wq_write_guard (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .vcc_low(vcc_low), .wr_strobe(wr_strobe), .cmd_reset(cmd_reset)
    );

    // behavioural reference model
    bit m_sh [3][SYNC];
    bit m_lk [SYNC];
    bit m_filt [3];
    int m_cnt [3];
    int m_st;
    bit m_strobe, m_creset;

    always @(posedge clk) begin
        bit pv [3];
        pv[2] = ce_n; pv[1] = we_n; pv[0] = oe_n;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < SYNC; j++) m_sh[i][j] = 0;
                m_filt[i] = 0; m_cnt[i] = 0;
            end
            for (int j = 0; j < SYNC; j++) m_lk[j] = 1;
            m_st = 0; m_strobe = 0; m_creset = 1;
        end else begin
            bit lk, c, w, o;
            lk = m_lk[SYNC-1]; c = m_filt[2]; w = m_filt[1]; o = m_filt[0];
            m_strobe = 0;
            if (lk) m_st = 0;
            else if (m_st == 0) begin
                if (c || w) m_st = 1;
            end else if (m_st == 1) begin
                if (!c && !w && o) m_st = 2;
            end else begin
                if (!o) m_st = (c || w) ? 1 : 0;
                else if (c || w) begin m_strobe = 1; m_st = 1; end
            end
            m_creset = lk;
            for (int i = 0; i < 3; i++) begin
                if (m_sh[i][SYNC-1] == m_filt[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == G-1) begin m_filt[i] = m_sh[i][SYNC-1]; m_cnt[i] = 0; end
                else m_cnt[i]++;
                for (int j = SYNC-1; j > 0; j--) m_sh[i][j] = m_sh[i][j-1];
                m_sh[i][0] = pv[i];
            end
            for (int j = SYNC-1; j > 0; j--) m_lk[j] = m_lk[j-1];
            m_lk[0] = vcc_low;
        end
    end

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check_eq("R5 wr_strobe vs model", int'(wr_strobe), int'(m_strobe));
            check_eq("R7 cmd_reset vs model", int'(cmd_reset), int'(m_creset));
        end
        if (wr_strobe === 1'b1) nstrobe++;
    end

    task automatic pins(logic c, logic w, logic o, int n);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o;
        repeat (n) @(posedge clk);
    endtask

    task automatic settle();
        pins(1, 1, 1, 20);
    endtask

    task automatic expect_writes(string req, int base, int exp);
        @(negedge clk);
        check_eq(req, nstrobe - base, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin
        int base;
        // R6: write combination already present at power-up
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_eq("R1 strobe in reset", int'(wr_strobe), 0);
        check_eq("R1 cmd_reset in reset", int'(cmd_reset), 1);
        cmp_en = 1;
        rst = 0;
        base = nstrobe;
        repeat (20) @(posedge clk);
        pins(0, 1, 1, 20);
        expect_writes("R6 power-up write refused", base, 0);
        check_eq("R1 cmd_reset released", int'(cmd_reset), 0);

        // R3/R5: ordinary write after release
        settle(); base = nstrobe;
        pins(0, 0, 1, 10); settle();
        expect_writes("R5 normal write", base, 1);

        // R2: pulse one sample short of the threshold
        base = nstrobe;
        pins(0, 1, 1, 10);
        pins(0, 0, 1, G-1); pins(0, 1, 1, 20); settle();
        expect_writes("R2 short we pulse ignored", base, 0);

        // R2: pulse exactly at the threshold
        base = nstrobe;
        pins(0, 1, 1, 10);
        pins(0, 0, 1, G); pins(0, 1, 1, 20); settle();
        expect_writes("R2 threshold pulse accepted", base, 1);

        // R2: short high glitch on we during a write does not split it
        base = nstrobe;
        pins(0, 0, 1, 10); pins(0, 1, 1, G-1); pins(0, 0, 1, 10); settle();
        expect_writes("R2 high glitch ignored", base, 1);

        // R3: oe low inhibits
        base = nstrobe;
        pins(0, 0, 0, 10); pins(1, 1, 0, 10); settle();
        expect_writes("R3 oe low inhibits", base, 0);

        // R3: ce high inhibits
        base = nstrobe;
        pins(1, 0, 1, 10); settle();
        expect_writes("R3 ce high inhibits", base, 0);

        // R4: oe falls during armed write
        base = nstrobe;
        pins(0, 0, 1, 10); pins(0, 0, 0, 10); pins(0, 0, 1, 10); settle();
        expect_writes("R4 oe abort", base, 0);

        // R9: write ended by ce
        base = nstrobe;
        pins(1, 0, 1, 5); pins(0, 0, 1, 10); pins(1, 0, 1, 20); settle();
        expect_writes("R9 ce-ended write", base, 1);

        // R7: lockout blocks writes and resets command logic
        base = nstrobe;
        @(negedge clk); vcc_low = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_eq("R7 cmd_reset under lockout", int'(cmd_reset), 1);
        pins(0, 0, 1, 10); settle();
        expect_writes("R7 write under lockout ignored", base, 0);
        @(negedge clk); vcc_low = 0;
        repeat (5) @(posedge clk);
        base = nstrobe;
        pins(0, 0, 1, 10); settle();
        expect_writes("R8 write after lockout release", base, 1);

        // R7/R8: lockout during armed write, pins still low after release
        base = nstrobe;
        pins(0, 0, 1, 10);
        @(negedge clk); vcc_low = 1;
        repeat (5) @(posedge clk);
        @(negedge clk); vcc_low = 0;
        repeat (10) @(posedge clk);
        settle();
        expect_writes("R8 aborted write not accepted", base, 0);

        settle();
        finish_run();
    end
endmodule